// File: doc/BRIEF.md
# Fault-First Vector Load Sequencer

This block carries out one vector load instruction as a series of element loads. A start pulse hands it a base byte address, a signed immediate step and the number of elements wanted. Element i is fetched from base plus step times i. The indices run upward from zero, and only one memory request is in flight at any time. Each returned word is written into an internal element buffer, which the surrounding datapath reads through a combinational read port.

Element 0 is mandatory. If it faults, the instruction traps. A fault on any later element does not trap. It stops the run and shortens the vector length to the number of elements already loaded. The block ends each instruction with a one-cycle done pulse that carries the final length and the trap flag.

Top module: `ffld_seq`

## Requirements
- R1: A start pulse is accepted only while busy_o is low. busy_o is high from the cycle after an accepted start through the done cycle. A start pulse seen while busy_o is high has no effect on the running instruction or its result.
- R2: The k-th request of an instruction has address base + sign-extended(imm) * k, taken modulo 2^32. k starts at 0 and rises by one per request.
- R3: req_valid_o is high for exactly one cycle per element. No new request is issued until rsp_valid_i has returned for the previous one.
- R4: A response with rsp_fault_i low for element k writes rsp_data_i into buffer entry k. rd_data_o then shows that entry when rd_idx_i = k.
- R5: If every element succeeds, done_o pulses with len_o equal to the effective count and trap_o low.
- R6: A fault on element 0 ends the instruction. done_o pulses with trap_o high and len_o = 0.
- R7: A fault on element k > 0 ends the instruction. done_o pulses with trap_o low and len_o = k, and no further request is issued.
- R8: A faulting response writes nothing. After an instruction ends, buffer entries at or above len_o keep the contents they had before it.
- R9: A requested count of 0 makes done_o pulse in the cycle after the start, with len_o = 0 and trap_o low, and no request is issued.
- R10: done_o is high for exactly one cycle per instruction, and busy_o is low in the cycle after it.
- R11: A requested count above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an instruction (one-cycle pulse) |
| base_i | input | 32 | Base byte address |
| imm_i | input | 16 | Signed per-element address step |
| count_i | input | 7 | Requested element count |
| busy_o | output | 1 | Instruction in progress |
| req_valid_o | output | 1 | Memory request, one cycle |
| req_addr_o | output | 32 | Request byte address |
| rsp_valid_i | input | 1 | Memory response present |
| rsp_fault_i | input | 1 | Response is a fault |
| rsp_data_i | input | 32 | Response data |
| rd_idx_i | input | 6 | Buffer read index |
| rd_data_o | output | 32 | Buffer read data |
| done_o | output | 1 | Instruction finished, one cycle |
| len_o | output | 7 | Final vector length, valid with done_o |
| trap_o | output | 1 | Trap required, valid with done_o |

## Verification
The hardest case to reach is a truncation whose effect on the buffer is visible. The buffer must already hold known data in entries above the fault point, and only then does a later instruction fault partway through. The bench first runs complete loads from other bases to fill the entries. It then injects a fault at a chosen request number, so the bench's shadow copy can show which entries must stay unchanged. Fault injection on the first element, on the last element of a 64-element run and on a middle element covers the three fault outcomes. A stray start pulse during a run shows that the inputs are latched at the start.

// File: rtl/ffld_pkg.sv
package ffld_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } ffld_state_e;

  // Closed-form element address, wide enough for any address width up to 64.
  function automatic logic [63:0] ea_calc(input logic [63:0] base,
                                          input logic [63:0] step,
                                          input logic [63:0] idx);
    return base + step * idx;
  endfunction

  // Clamp a requested count to the buffer depth.
  function automatic int unsigned clamp_cnt(input int unsigned req,
                                            input int unsigned max_elems);
    return (req > max_elems) ? max_elems : req;
  endfunction

endpackage

// File: rtl/ffld_addr_gen.sv
module ffld_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] step_o
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] base_q, step_q, addr_q;
  logic [ADDR_W-1:0] step_ext;

  assign step_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  // Running address: one adder step per element, no multiplier in the path.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      step_q <= step_ext;
      addr_q <= base_i;
    end else if (adv_i) begin
      addr_q <= addr_q + step_q;
    end
  end

  assign addr_o = addr_q;
  assign base_o = base_q;
  assign step_o = step_q;
endmodule

// File: rtl/ffld_elem_buf.sv
module ffld_elem_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/ffld_ctrl.sv
module ffld_ctrl
  import ffld_pkg::*;
#(
  parameter int MAX_ELEMS = 64,
  parameter int CNT_W     = $clog2(MAX_ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_fault_i,
  output logic             busy_o,
  output logic             issue_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             done_o,
  output logic [CNT_W-1:0] len_o,
  output logic             trap_o,
  // named events for checking
  output logic             ev_trap_o,
  output logic             ev_trunc_o,
  output logic             ev_last_o
);
  ffld_state_e      state_q;
  logic [CNT_W-1:0] idx_q, cnt_q, len_q, eff_cnt;
  logic             trap_q;
  logic             accept, rsp_here, last_elem;

  assign eff_cnt   = CNT_W'(clamp_cnt(int'(count_i), MAX_ELEMS));
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign rsp_here  = (state_q == ST_WAIT) && rsp_valid_i;
  assign last_elem = (idx_q + CNT_W'(1)) == cnt_q;

  assign ev_trap_o  = rsp_here && rsp_fault_i && (idx_q == '0);
  assign ev_trunc_o = rsp_here && rsp_fault_i && (idx_q != '0);
  assign ev_last_o  = rsp_here && !rsp_fault_i && last_elem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      trap_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cnt_q  <= eff_cnt;
          idx_q  <= '0;
          len_q  <= '0;
          trap_q <= 1'b0;
          state_q <= (eff_cnt == '0) ? ST_DONE : ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          if (rsp_fault_i) begin
            len_q   <= idx_q;
            trap_q  <= (idx_q == '0);
            state_q <= ST_DONE;
          end else if (last_elem) begin
            len_q   <= cnt_q;
            trap_q  <= 1'b0;
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_q + CNT_W'(1);
            state_q <= ST_ISSUE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign issue_o = (state_q == ST_ISSUE);
  assign load_o  = accept;
  assign adv_o   = rsp_here && !rsp_fault_i && !last_elem;
  assign wr_en_o = rsp_here && !rsp_fault_i;
  assign idx_o   = idx_q;
  assign done_o  = (state_q == ST_DONE);
  assign len_o   = len_q;
  assign trap_o  = trap_q;

  // R6
  trap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap_o |=> (done_o && trap_o && (len_o == '0)));

  // R7
  trunc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trunc_o |=> (done_o && !trap_o && (len_o == $past(idx_q))));

  // R5
  full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_o |=> (done_o && !trap_o && (len_o == cnt_q)));

  // R3
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |=> !issue_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R9
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (count_i == '0)) |=> (done_o && (len_o == '0) && !trap_o));

  // R11
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q <= CNT_W'(MAX_ELEMS)));

  // R1
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> (busy_o && $stable(cnt_q)));
endmodule

// File: rtl/ffld_seq.sv
module ffld_seq #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter int MAX_ELEMS = 64,
  parameter int CNT_W     = $clog2(MAX_ELEMS + 1),
  parameter int IDX_W     = $clog2(MAX_ELEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_fault_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              trap_o
);
  logic             load, adv, wr_en;
  logic             ev_trap, ev_trunc, ev_last;
  logic [CNT_W-1:0] idx;
  logic [ADDR_W-1:0] base_l, step_l;

  ffld_ctrl #(.MAX_ELEMS(MAX_ELEMS), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .count_i    (count_i),
    .rsp_valid_i(rsp_valid_i),
    .rsp_fault_i(rsp_fault_i),
    .busy_o     (busy_o),
    .issue_o    (req_valid_o),
    .load_o     (load),
    .adv_o      (adv),
    .wr_en_o    (wr_en),
    .idx_o      (idx),
    .done_o     (done_o),
    .len_o      (len_o),
    .trap_o     (trap_o),
    .ev_trap_o  (ev_trap),
    .ev_trunc_o (ev_trunc),
    .ev_last_o  (ev_last)
  );

  ffld_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load),
    .base_i(base_i),
    .imm_i (imm_i),
    .adv_i (adv),
    .addr_o(req_addr_o),
    .base_o(base_l),
    .step_o(step_l)
  );

  ffld_elem_buf #(.DATA_W(DATA_W), .DEPTH(MAX_ELEMS), .IDX_W(IDX_W)) u_buf (
    .clk      (clk),
    .wr_en_i  (wr_en),
    .wr_idx_i (idx[IDX_W-1:0]),
    .wr_data_i(rsp_data_i),
    .rd_idx_i (rd_idx_i),
    .rd_data_o(rd_data_o)
  );

  // R2
  ea_formula_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_addr_o ==
      ADDR_W'(ffld_pkg::ea_calc(64'(base_l), 64'(step_l), 64'(idx)))));

  // R8
  fault_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_trap || ev_trunc) |-> !wr_en);

  // R4
  write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rsp_valid_i && busy_o && !ev_last || ev_last));
endmodule

// File: tb/ffld_seq_tb.sv
module ffld_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] imm_i = '0;
  logic [6:0]  count_i = '0;
  logic        busy_o, req_valid_o, done_o, trap_o;
  logic [31:0] req_addr_o, rd_data_o;
  logic        rsp_valid_i = 1'b0, rsp_fault_i = 1'b0;
  logic [31:0] rsp_data_i = '0;
  logic [5:0]  rd_idx_i = '0;
  logic [6:0]  len_o;

  int checks = 0, errors = 0;

  logic [31:0] exp_q[$];
  int          fault_at = 1000, latency = 0, req_seen = 0;
  bit          pend = 0;
  int          wait_left = 0;
  int          cur_idx = 0;
  logic [31:0] cur_addr = '0;
  logic [31:0] shadow [MAXE];
  bit          shadow_v [MAXE];

  always #(CLK_PERIOD/2) clk = ~clk;

  ffld_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .imm_i(imm_i), .count_i(count_i), .busy_o(busy_o),
    .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
    .rsp_valid_i(rsp_valid_i), .rsp_fault_i(rsp_fault_i),
    .rsp_data_i(rsp_data_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .done_o(done_o), .len_o(len_o), .trap_o(trap_o)
  );

  function automatic logic [31:0] data_of(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [31:0] addr_of(input logic [31:0] b,
                                          input logic [15:0] imm, input int k);
    logic [31:0] s;
    s = {{16{imm[15]}}, imm};
    return b + s * 32'(k);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor and memory model: pops expected addresses, answers after latency.
  always @(negedge clk) begin
    if (rsp_valid_i) rsp_valid_i = 1'b0;
    if (req_valid_o) begin
      chk("R3 request while one outstanding", {63'd0, pend}, 64'd0);
      if (exp_q.size() == 0) begin
        chk("R7 unexpected extra request", 64'd1, 64'd0);
      end else begin
        chk("R2 request address", {32'd0, req_addr_o}, {32'd0, exp_q.pop_front()});
      end
      pend = 1'b1;
      wait_left = latency;
      cur_idx = req_seen;
      cur_addr = req_addr_o;
      req_seen++;
    end else if (pend) begin
      if (wait_left == 0) begin
        rsp_valid_i = 1'b1;
        rsp_fault_i = (cur_idx == fault_at);
        rsp_data_i  = data_of(cur_addr);
        pend = 1'b0;
      end else begin
        wait_left--;
      end
    end
  end

  task automatic run_op(input logic [31:0] b, input logic [15:0] imm,
                        input int cnt, input int fidx, input int lat,
                        input bit poke);
    int eff, nreq, exp_len, cyc;
    bit exp_trap;
    eff = (cnt > MAXE) ? MAXE : cnt;
    nreq = (fidx < eff) ? fidx + 1 : eff;
    exp_len = (fidx < eff) ? fidx : eff;
    exp_trap = (fidx == 0) && (eff > 0);
    for (int i = 0; i < nreq; i++) exp_q.push_back(addr_of(b, imm, i));
    fault_at = fidx;
    latency = lat;
    req_seen = 0;
    @(negedge clk);
    start_i = 1'b1; base_i = b; imm_i = imm; count_i = 7'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    chk("R1 busy after start", {63'd0, busy_o}, 64'd1);
    cyc = 1;
    while (!done_o && cyc < 2000) begin
      if (poke && cyc == 3) begin
        start_i = 1'b1; count_i = 7'd2; base_i = 32'hDEAD_0000;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk("R10 done seen", {63'd0, done_o}, 64'd1);
    if (cnt == 0) chk("R9 zero count done timing", 64'(cyc), 64'd1);
    chk("R5/R6/R7 final length", {57'd0, len_o}, 64'(exp_len));
    chk("R6/R7 trap flag", {63'd0, trap_o}, {63'd0, exp_trap});
    chk("R7 all expected requests issued", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    @(negedge clk);
    chk("R10 done is one cycle", {63'd0, done_o}, 64'd0);
    chk("R10 idle after done", {63'd0, busy_o}, 64'd0);
    chk("R9/R7 request count", 64'(req_seen), 64'(nreq));
    for (int i = 0; i < exp_len; i++) begin
      shadow[i] = data_of(addr_of(b, imm, i));
      shadow_v[i] = 1'b1;
    end
    for (int i = 0; i < MAXE; i++) begin
      if (shadow_v[i]) begin
        rd_idx_i = 6'(i);
        #1;
        chk((i < exp_len) ? "R4 buffer entry" : "R8 entry kept",
            {32'd0, rd_data_o}, {32'd0, shadow[i]});
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAXE; i++) shadow_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy low", {63'd0, busy_o}, 64'd0);
    chk("R10 reset done low", {63'd0, done_o}, 64'd0);
    chk("R3 reset no request", {63'd0, req_valid_o}, 64'd0);
    // R5 complete load, positive step
    run_op(32'h0000_1000, 16'd4, 8, 1000, 2, 1'b0);
    // R2 negative step, zero latency
    run_op(32'h2000_0040, 16'hFFF8, 5, 1000, 0, 1'b0);
    // R7/R8 truncation at element 5
    run_op(32'h0000_3000, 16'd4, 8, 5, 1, 1'b0);
    // R6 fault on first element, buffer untouched
    run_op(32'h0000_4000, 16'd4, 6, 0, 1, 1'b0);
    // R9 zero count
    run_op(32'h0000_5000, 16'd4, 0, 1000, 0, 1'b0);
    // R11 clamp of 100 to 64
    run_op(32'h0001_0000, 16'd1, 100, 1000, 0, 1'b0);
    // R7 fault on the last of 64
    run_op(32'h0002_0000, 16'd2, 64, 63, 0, 1'b0);
    // R1 start while busy is ignored
    run_op(32'h0003_0000, 16'hFFFF, 10, 1000, 3, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule